// File: doc/BRIEF.md
# Passive Identification Beacon Core

This block is the digital heart of a passive identification tag that never waits for a command. It runs on the clock recovered from the reader's 13.56 MHz field. From power-on it repeats a fixed schedule: first a silent stretch, then a burst that carries one 128-bit identification word, then silence again, for as long as the field supplies power. The only output is an enable for the analogue load modulator. The analogue front end sets that enable to change the load the tag presents to the field.

The identification word has three parts. The low 96 bits are fixed when the block is built. Sixteen user bits and a sixteen-bit check code come in on programmable input pins. The check code is computed off-chip and stored with the other bits; the block does not compute it. The bit period is 128 carrier cycles, which gives about 106 kbit/s. Each bit is Manchester coded as on-off keying of a subcarrier at one sixteenth of the carrier frequency. Before bit 0 comes a start bit, coded the same way as a logic 1.

The block has no streaming data interface. The programmable bits are static configuration pins and have no handshake, so there is no back-pressure.

Top module: `id_beacon_core`

## Requirements
- R1: While reset is asserted, and for the first GAP_BITS bit periods after reset is released, `mod_en` is 0. The block always starts with a silent gap.
- R2: One bit period is 2^DIV_STAGES carrier cycles, 128 by default. All period boundaries are counted from the release of reset.
- R3: A burst lasts WORD_BITS+1 bit periods, 129 by default. It is one start bit followed by the word bits.
- R4: Each burst is followed by a silent gap of GAP_BITS bit periods, 381 by default. Gap and burst then repeat without end.
- R5: Manchester coding. A logic 1, and the start bit, are modulated in the first half of their bit period. A logic 0 is modulated in the second half. The unmodulated half keeps `mod_en` at 0.
- R6: Inside a modulated half, `mod_en` follows a subcarrier: 1 for 8 carrier cycles, then 0 for 8, starting at 1 on the first cycle of the half. `mod_en` is a registered output, so it reflects the state one carrier cycle later.
- R7: Word bits are sent in order from index 0 to index 127. Indices 0 to 95 come from the FIXED_WORD parameter, with bit i at index i. `otp_bits[15:0]` fill indices 96 to 111. `otp_bits[31:16]`, the check code, fill indices 112 to 127.
- R8: `otp_bits` is sampled once per burst, on the clock edge that ends the gap. A change at any other time has no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-derived clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| otp_bits | input | OTP_BITS (32) | Programmable user bits [15:0] and check code [31:16] |
| mod_en | output | 1 | Load-modulator enable |

## Verification
Two things can happen on the same clock edge: the programmable pins can change, and the block can capture them at the end of a gap. The bench writes a new value onto `otp_bits` half a cycle before that capture edge. It writes a different value half a cycle after the edge, and then changes the pins again in the middle of the burst. The bench model takes its expected word from the value present at the capture edge. It compares `mod_en` against that word on every carrier cycle, so the wrong choice of word shows up as a mismatch in the data bits. A second reset, applied in the middle of a gap, confirms that the schedule restarts from a fresh silent stretch.

// File: rtl/idb_pkg.sv
package idb_pkg;
  typedef enum logic [1:0] {
    PH_GAP  = 2'd0,
    PH_SOF  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/bit_clock_divider.sv
module bit_clock_divider #(
  parameter int STAGES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] phase,
  output logic              period_end
);
  logic [STAGES:0]   carry;
  logic [STAGES-1:0] stage_q;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] & stage_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_q[i] ^ carry[i];
    end
  end

  assign phase      = stage_q;
  assign period_end = carry[STAGES];
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import idb_pkg::*;
#(
  parameter int WORD_BITS = 128,
  parameter int OTP_BITS  = 32,
  parameter int GAP_BITS  = 381,
  parameter logic [WORD_BITS-OTP_BITS-1:0] FIXED_WORD = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                period_end,
  input  logic [OTP_BITS-1:0] otp_bits,
  output logic                active,
  output logic                bit_val
);
  localparam int MAX_SLOTS = (GAP_BITS > WORD_BITS) ? GAP_BITS : WORD_BITS;
  localparam int SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
  localparam logic [SLOT_W-1:0] GAP_LAST  = SLOT_W'(GAP_BITS - 1);
  localparam logic [SLOT_W-1:0] WORD_LAST = SLOT_W'(WORD_BITS - 1);

  phase_e               ph_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [WORD_BITS-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_GAP;
      slot_q <= '0;
      word_q <= '0;
    end else if (period_end) begin
      unique case (ph_q)
        PH_GAP: begin
          if (slot_q == GAP_LAST) begin
            ph_q   <= PH_SOF;
            slot_q <= '0;
            word_q <= {otp_bits, FIXED_WORD};
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        PH_SOF: begin
          ph_q   <= PH_DATA;
          slot_q <= '0;
        end
        PH_DATA: begin
          word_q <= word_q >> 1;
          if (slot_q == WORD_LAST) begin
            ph_q   <= PH_GAP;
            slot_q <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: begin
          ph_q   <= PH_GAP;
          slot_q <= '0;
        end
      endcase
    end
  end

  assign active  = (ph_q != PH_GAP);
  assign bit_val = (ph_q == PH_SOF) ? 1'b1 : word_q[0];
endmodule

// File: rtl/manchester_modulator.sv
module manchester_modulator #(
  parameter int DIV_STAGES = 7,
  parameter int SUB_LOG    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic                  bit_val,
  input  logic [DIV_STAGES-1:0] phase,
  output logic                  mod_en
);
  logic second_half;
  logic sub_on;
  logic in_half;
  logic mod_q;

  assign second_half = phase[DIV_STAGES-1];
  assign sub_on      = ~phase[SUB_LOG];
  assign in_half     = bit_val ? ~second_half : second_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_q <= 1'b0;
    else        mod_q <= active & in_half & sub_on;
  end

  assign mod_en = mod_q;
endmodule

// File: rtl/id_beacon_core.sv
module id_beacon_core #(
  parameter int DIV_STAGES = 7,
  parameter int SUB_LOG    = 3,
  parameter int WORD_BITS  = 128,
  parameter int OTP_BITS   = 32,
  parameter int GAP_BITS   = 381,
  parameter logic [WORD_BITS-OTP_BITS-1:0] FIXED_WORD = 96'hA5C3_0F1E_7B29_D486_3C5A_E01F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OTP_BITS-1:0] otp_bits,
  output logic                mod_en
);
  logic [DIV_STAGES-1:0] phase;
  logic                  period_end;
  logic                  seq_active;
  logic                  seq_bit;

  bit_clock_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .period_end (period_end)
  );

  frame_sequencer #(
    .WORD_BITS  (WORD_BITS),
    .OTP_BITS   (OTP_BITS),
    .GAP_BITS   (GAP_BITS),
    .FIXED_WORD (FIXED_WORD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_end (period_end),
    .otp_bits   (otp_bits),
    .active     (seq_active),
    .bit_val    (seq_bit)
  );

  manchester_modulator #(
    .DIV_STAGES (DIV_STAGES),
    .SUB_LOG    (SUB_LOG)
  ) u_mod (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (seq_active),
    .bit_val (seq_bit),
    .phase   (phase),
    .mod_en  (mod_en)
  );
endmodule

// File: rtl/id_beacon_core_chk.sv
module id_beacon_core_chk #(
  parameter int DIV_STAGES = 7,
  parameter int WORD_BITS  = 128,
  parameter int GAP_BITS   = 381
) (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic active,
  input logic period_end
);
  localparam int GAP_CYC   = GAP_BITS << DIV_STAGES;
  localparam int BURST_CYC = (WORD_BITS + 1) << DIV_STAGES;

  int idle_cnt;
  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= 0;
      busy_cnt <= 0;
    end else begin
      idle_cnt <= active ? 0 : idle_cnt + 1;
      busy_cnt <= active ? busy_cnt + 1 : 0;
    end
  end

  // R1
  gap_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> idle_cnt == GAP_CYC);

  // R3
  burst_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> busy_cnt == BURST_CYC);

  // R2
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(period_end) |-> $stable(active));

  // R4
  silent_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |-> $past(active));

  // R6
  sub_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_en) |=> !mod_en);
endmodule

bind id_beacon_core id_beacon_core_chk #(
  .DIV_STAGES (DIV_STAGES),
  .WORD_BITS  (WORD_BITS),
  .GAP_BITS   (GAP_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_en     (mod_en),
  .active     (seq_active),
  .period_end (period_end)
);

// File: tb/id_beacon_core_test.sv
module id_beacon_core_test;
  localparam int TB_GAP = 6;
  localparam int PER    = 128;
  localparam int FRAME  = (TB_GAP + 129) * PER;
  localparam int CAP    = TB_GAP * PER;
  localparam logic [95:0] FIXED = 96'hA5C3_0F1E_7B29_D486_3C5A_E01F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] otp_bits = 32'h0;
  logic        mod_en;

  int checks = 0;
  int failures = 0;
  int e_cnt = 0;
  int cyc = 0;
  int first_rise = -1;
  logic prev_mod = 1'b0;
  logic [127:0] exp_word = '0;

  always #4 clk = ~clk;

  id_beacon_core #(.GAP_BITS(TB_GAP)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .otp_bits (otp_bits),
    .mod_en   (mod_en)
  );

  function automatic logic model(input int x, input logic [127:0] w);
    int fp, p, d;
    logic b;
    fp = x % FRAME;
    p  = fp / PER;
    d  = fp % PER;
    if (p < TB_GAP) return 1'b0;
    b = (p == TB_GAP) ? 1'b1 : w[p - TB_GAP - 1];
    return ((d % 16) < 8) && (b ? (d < 64) : (d >= 64));
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at e=%0d: actual=%0d expected=%0d", req, e_cnt, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) e_cnt <= 0;
    else begin
      e_cnt <= e_cnt + 1;
      if ((e_cnt + 1) % FRAME == CAP) exp_word <= {otp_bits, FIXED};
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog: actual=%0d expected=<190000", cyc);
      report();
    end
  end

  always @(negedge clk) begin
    string tag;
    logic  exp;
    int    fp;
    if (!rst_n) begin
      check(mod_en == 1'b0, "R1 reset", mod_en, 0);
    end else begin
      exp = (e_cnt == 0) ? 1'b0 : model(e_cnt - 1, exp_word);
      fp  = (e_cnt == 0) ? 0 : (e_cnt - 1) % FRAME;
      if (e_cnt - 1 < CAP)          tag = "R1 first gap";
      else if (fp < CAP)            tag = "R4 gap";
      else if (fp < CAP + PER)      tag = "R3 start bit";
      else                          tag = "R5,R6,R7,R8 data";
      check(mod_en == exp, tag, mod_en, exp);
      if (mod_en && !prev_mod && first_rise < 0) first_rise = e_cnt;
    end
    prev_mod = mod_en;
  end

  task automatic wait_e(input int target);
    while (e_cnt != target) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wait_e(k * FRAME + CAP - 1);
      if (k == 0)      otp_bits = 32'hFFFF_FFFF;
      else if (k == 1) otp_bits = 32'h0000_0000;
      else             otp_bits = $urandom;
      @(negedge clk);
      otp_bits = $urandom;          // R8: too late for this burst
      wait_e(k * FRAME + CAP + 3000);
      otp_bits = $urandom;          // R8: mid-burst change
    end
    wait_e(5 * FRAME + CAP + 129 * PER + 200);
    // R2: first modulation begins one cycle after the gap ends
    check(first_rise == CAP + 1, "R2 first rise", first_rise, CAP + 1);
    rst_n = 1'b0;
    first_rise = -1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_e(CAP + 129 * PER + 100);
    check(first_rise == CAP + 1, "R1 restart rise", first_rise, CAP + 1);
    report();
  end
endmodule